// File: doc/BRIEF.md
# Counter-Field Incrementer for Counter-Mode Blocks

This block adds one to a counter embedded in a 128-bit data block, the step that advances the input block between successive counter-mode cipher operations. Three run-time settings control the update. A size selector picks the counter width. An alignment bit anchors a sub-128-bit field in the upper or lower half of the block. An ordering bit decides which octet holds the least significant byte and which way the carry travels between octets.

A caller presents a block and the settings, then pulses `step` for one cycle. On the next cycle `blk_out` holds the block with the counter field advanced by one. Every octet outside the field keeps its value. Between pulses the output register holds its value.

Top module: `ctr_field_incr`

## Requirements
- R1: While `rst_n` is low, `blk_out` is all zeros.
- R2: In a cycle where `step` is low, `blk_out` keeps its value.
- R3: With `size_sel` = 0 (counting off), a `step` loads `blk_in` into `blk_out` unchanged.
- R4: With `size_sel` = 6 or 7 (unsupported), a `step` loads `blk_in` into `blk_out` unchanged.
- R5: `size_sel` values 1, 2, 3 and 4 select a counter of 8, 16, 32 and 64 bits (1, 2, 4 and 8 octets). Octet k is bits [8k+7:8k] of the block.
- R6: With `align_right` = 1 and a size of 8 to 64 bits, the field ends at octet 15, and octets 0 to 7 are never modified.
- R7: With `align_right` = 0 and a size of 8 to 64 bits, the field starts at octet 0, and octets 8 to 15 are never modified.
- R8: `size_sel` = 5 selects a 128-bit counter over all 16 octets, whatever the value of `align_right`.
- R9: With `carry_down` = 1, the least significant octet is the highest-numbered octet of the field, and a carry passes from octet n to octet n-1.
- R10: With `carry_down` = 0, the least significant octet is the lowest-numbered octet of the field, and a carry passes from octet n to octet n+1.
- R11: The counter wraps modulo 2^width. A field of all 0xFF octets becomes all zeros, and the carry out of the field is dropped.
- R12: The result of a `step` on cycle t appears on `blk_out` after the clock edge that ends cycle t. With a valid size, that result always differs from the `blk_in` sampled on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_in | input | 128 | Block holding the counter field |
| size_sel | input | 3 | Counter size code: 0 off, 1..5 = 8/16/32/64/128 bits |
| align_right | input | 1 | 1: field in octets 8..15, 0: field in octets 0..7 |
| carry_down | input | 1 | 1: carry to lower octet number, 0: carry to higher |
| step | input | 1 | One-cycle pulse that registers the incremented block |
| blk_out | output | 128 | Registered result block |

## Verification
The assertions check four things on every cycle. The output holds when no pulse arrives. A disabled or unsupported size code copies the input straight through. A valid increment always changes the block. The half of the block opposite the anchored field is never touched. Only the bench scenarios can show the exact value of the counter field. That covers which octet ranks lowest, how far a carry ripples in each direction, and the wrap of an all-0xFF field. The bench compares against a model that packs the field into an integer, adds one and unpacks it, for every size code, alignment and ordering.

// File: rtl/ctr_field_incr.sv
module ctr_field_incr #(
  parameter int BLOCK_BITS = 128
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [BLOCK_BITS-1:0] blk_in,
  input  logic [2:0]            size_sel,
  input  logic                  align_right,
  input  logic                  carry_down,
  input  logic                  step,
  output logic [BLOCK_BITS-1:0] blk_out
);
  localparam int NOCT = BLOCK_BITS / 8;
  localparam int IW   = $clog2(NOCT) + 1;

  logic [IW-1:0]         span;
  logic [IW-1:0]         base;
  logic                  valid;
  logic [NOCT-1:0]       fld;
  logic [IW-1:0]         rank [NOCT];
  logic [BLOCK_BITS-1:0] nxt;

  always_comb begin
    case (size_sel)
      3'd1:    span = IW'(1);
      3'd2:    span = IW'(2);
      3'd3:    span = IW'(4);
      3'd4:    span = IW'(8);
      3'd5:    span = IW'(NOCT);
      default: span = '0;
    endcase
  end

  assign valid = (span != '0);
  assign base  = (size_sel == 3'd5 || !align_right) ? '0 : IW'(NOCT) - span;

  always_comb begin
    for (int i = 0; i < NOCT; i++) begin
      fld[i]  = valid && (IW'(i) >= base) && (IW'(i) < base + span);
      rank[i] = carry_down ? (base + span - IW'(1) - IW'(i)) : (IW'(i) - base);
    end
  end

  always_comb begin
    logic bump;
    for (int i = 0; i < NOCT; i++) begin
      bump = fld[i];
      for (int j = 0; j < NOCT; j++)
        if (fld[j] && (rank[j] < rank[i]) && (blk_in[8*j +: 8] != 8'hFF))
          bump = 1'b0;
      nxt[8*i +: 8] = blk_in[8*i +: 8] + {7'd0, bump};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    blk_out <= '0;
    else if (step) blk_out <= nxt;
  end
endmodule

module ctr_field_incr_chk #(
  parameter int BLOCK_BITS = 128
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [BLOCK_BITS-1:0] blk_in,
  input logic [2:0]            size_sel,
  input logic                  align_right,
  input logic                  carry_down,
  input logic                  step,
  input logic [BLOCK_BITS-1:0] blk_out
);
  localparam int HB = BLOCK_BITS / 2;

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(blk_out)); // R2
  AST_OFF_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (step && size_sel == 3'd0) |=> blk_out == $past(blk_in)); // R3
  AST_BAD_CODE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (step && size_sel > 3'd5) |=> blk_out == $past(blk_in)); // R4
  AST_LOW_HALF_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (step && align_right && size_sel >= 3'd1 && size_sel <= 3'd4)
      |=> blk_out[HB-1:0] == $past(blk_in[HB-1:0])); // R6
  AST_HIGH_HALF_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !align_right && size_sel >= 3'd1 && size_sel <= 3'd4)
      |=> blk_out[BLOCK_BITS-1:HB] == $past(blk_in[BLOCK_BITS-1:HB])); // R7
  AST_STEP_CHANGES: assert property (@(posedge clk) disable iff (!rst_n)
    (step && size_sel >= 3'd1 && size_sel <= 3'd5) |=> blk_out != $past(blk_in)); // R12
endmodule

bind ctr_field_incr ctr_field_incr_chk #(.BLOCK_BITS(BLOCK_BITS)) u_chk (.*);

// File: tb/test_ctr_field_incr.sv
module test_ctr_field_incr;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] blk_in = '0;
  logic [2:0]   size_sel = '0;
  logic         align_right = 1'b0;
  logic         carry_down = 1'b0;
  logic         step = 1'b0;
  logic [127:0] blk_out;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ctr_field_incr i_ctr_field_incr (.*);

  function automatic logic [127:0] model(logic [127:0] b, int code, bit ra, bit be);
    logic [127:0] v;
    logic [127:0] r;
    int w, lo, idx;
    if (code < 1 || code > 5) return b;
    w  = 1 << (code - 1);
    lo = (code == 5 || !ra) ? 0 : 16 - w;
    v  = '0;
    for (int k = 0; k < w; k++) begin
      idx = be ? lo + w - 1 - k : lo + k;
      v[8*k +: 8] = b[8*idx +: 8];
    end
    v = v + 128'd1;
    r = b;
    for (int k = 0; k < w; k++) begin
      idx = be ? lo + w - 1 - k : lo + k;
      r[8*idx +: 8] = v[8*k +: 8];
    end
    return r;
  endfunction

  task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(logic [127:0] b, int code, bit ra, bit be);
    @(negedge clk);
    blk_in = b; size_sel = 3'(code); align_right = ra; carry_down = be; step = 1'b1;
    @(negedge clk);
    step = 1'b0;
  endtask

  function automatic logic [127:0] pattern(int p, int code, bit ra, bit be);
    logic [127:0] b;
    int w, lo, lsb;
    b = {$urandom, $urandom, $urandom, $urandom};
    w = (code >= 1 && code <= 5) ? (1 << (code - 1)) : 1;
    lo = (code == 5 || !ra) ? 0 : 16 - w;
    lsb = be ? lo + w - 1 : lo;
    case (p)
      0: ;
      1: for (int k = lo; k < lo + w; k++) b[8*k +: 8] = 8'hFF;
      2: b[8*lsb +: 8] = 8'hFF;
      3: for (int k = lo; k < lo + w; k++) b[8*k +: 8] = 8'h00;
      default: ;
    endcase
    return b;
  endfunction

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [127:0] b, e, held;
    string tag;
    repeat (3) @(negedge clk);
    check("R1", blk_out, '0);
    rst_n = 1'b1;

    apply(128'h0, 3, 1'b1, 1'b1);
    check("R5", blk_out, 128'h01 << 120);
    apply(128'h0, 3, 1'b0, 1'b1);
    check("R5", blk_out, 128'h01 << 24);

    @(negedge clk);
    blk_in = 128'h5; size_sel = 3'd1; align_right = 1'b0; carry_down = 1'b0; step = 1'b1;
    check("R12", blk_out, 128'h01 << 24);
    @(negedge clk);
    step = 1'b0;
    check("R12", blk_out, 128'h6);

    for (int code = 0; code < 8; code++)
      for (int ra = 0; ra < 2; ra++)
        for (int be = 0; be < 2; be++)
          for (int p = 0; p < 4; p++) begin
            b = pattern(p, code, ra[0], be[0]);
            e = model(b, code, ra[0], be[0]);
            apply(b, code, ra[0], be[0]);
            if (code == 0) tag = "R3";
            else if (code > 5) tag = "R4";
            else if (code == 5) tag = "R8";
            else if (p == 1) tag = "R11";
            else if (be != 0) tag = "R9";
            else tag = "R10";
            check(tag, blk_out, e);
            if (code >= 1 && code <= 4) begin
              if (ra != 0) check("R6", blk_out[63:0], b[63:0]);
              else         check("R7", blk_out[127:64], b[127:64]);
            end
            held = blk_out;
            @(negedge clk);
            blk_in = ~b;
            @(negedge clk);
            check("R2", blk_out, held);
          end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule